// File: doc/BRIEF.md
# Dual-Database Ternary Search Engine

This block is a small pipelined ternary search engine that keeps two independent rule tables. Table A holds wide entries that match the full 252-bit search key; table B holds narrower 128-bit entries. Each entry is a value with a care mask: a mask bit of 1 demands equality on that key bit and a mask bit of 0 ignores it. Entries are loaded through a single write port that chooses the table, the slot, the value and the mask.

The host hands over one wide key per command. The command can also ask for a second lookup. In that case the engine takes a 128-bit window of the same key, starting at a bit offset held in a configuration register, and searches table B with it. The host never sends the narrow key again. Both answers leave on one result port as two words in consecutive cycles, each tagged with the command's tag and the table it came from. A dual command holds the command port not-ready for one cycle, so the result port never has to carry more than one word per cycle.

The search runs in stages. The first result word of a command appears exactly three cycles after the command is accepted, and single commands can stream at one per cycle.

Top module: `dual_lookup_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, `res_valid` is 0, no entry of either table is live (every lookup misses), and the window offset is 0.
- R2: A command accepted at clock edge k produces its table-A word (`res_db`=0, `res_tag` equal to the command's tag) visible after edge k+3 and not earlier. Without a command there is no table-A word.
- R3: Entry bit i takes part in the compare only when mask bit i is 1. A key that differs from an entry only in bits whose mask bit is 0 still hits.
- R4: When several live entries match, `res_idx` gives the lowest matching slot. On a miss `res_hit` is 0 and `res_idx` is 0.
- R5: A command with `cmd_dual`=1 produces a second word with `res_db`=1 and the same tag in the cycle right after its table-A word. A command with `cmd_dual`=0 produces no table-B word.
- R6: The table-B key is `cmd_key[off+127:off]`, where off is the offset register value at the acceptance edge. Offsets 0 through 124 are usable, including 124.
- R7: A write to the offset register with a value above 124 is ignored, and the previous offset stays in force.
- R8: After accepting a dual command `cmd_ready` is 0 for exactly one cycle. A single command does not lower `cmd_ready`.
- R9: An entry write takes effect for commands accepted after the write's edge. A command accepted at the same edge as the write still sees the old contents.
- R10: `wr_db`=0 writes table A with the full `wr_value`/`wr_mask`. `wr_db`=1 writes table B with their low 128 bits. A write to one table leaves the other table unchanged.
- R11: Single commands accepted on consecutive edges return their table-A words on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_key | input | 252 | Wide search key |
| cmd_dual | input | 1 | 1 asks for the extra table-B lookup |
| cmd_tag | input | 4 | Tag echoed on the result words |
| cfg_we | input | 1 | Write strobe for the window offset |
| cfg_off | input | 7 | New window offset (0..124) |
| wr_en | input | 1 | Entry write strobe |
| wr_db | input | 1 | Table select: 0 = A, 1 = B |
| wr_idx | input | 4 | Entry slot |
| wr_value | input | 252 | Entry value (low 128 bits for table B) |
| wr_mask | input | 252 | Care mask, 1 = compare (low 128 bits for table B) |
| res_valid | output | 1 | Result word present |
| res_hit | output | 1 | Lookup matched a live entry |
| res_idx | output | 4 | Lowest matching slot, 0 on miss |
| res_db | output | 1 | Table of this word: 0 = A, 1 = B |
| res_tag | output | 4 | Tag of the originating command |

## Verification
The bench overlaps two entries so that priority matters: a design that picks the highest slot, or that leaves a stale slot index on a miss, returns the wrong index. It moves the window offset to 100 and to the top value 124, then writes an out-of-range offset. A design that shifts by the wrong amount, rejects the top offset or accepts a bad offset searches table B with the wrong bits and lands on the catch-all slot instead of the exact one. It writes an entry in the same cycle as a lookup of that entry. A design that compares late lets the newer contents leak into the earlier command. It also streams commands back to back and counts the exact result cycles and the one-cycle stall, so a stage too many or too few, a dropped second word or a missing stall shows up as a word in the wrong cycle.

// File: rtl/dle_pkg.sv
package dle_pkg;
    parameter int KEY_W = 252;
    parameter int SUB_W = 128;
    parameter int DEPTH = 16;
    parameter int TAG_W = 4;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int MAX_OFF = KEY_W - SUB_W;
    localparam int OFF_W   = $clog2(MAX_OFF + 1);

    // stage 1: raw match vectors taken in the acceptance cycle
    typedef struct packed {
        logic             vld;
        logic             dual;
        logic [TAG_W-1:0] tag;
        logic [DEPTH-1:0] vec_a;
        logic [DEPTH-1:0] vec_b;
    } s1_t;

    // stage 2/3: encoded answers for both tables
    typedef struct packed {
        logic             vld;
        logic             dual;
        logic [TAG_W-1:0] tag;
        logic             hit_a;
        logic [IDX_W-1:0] idx_a;
        logic             hit_b;
        logic [IDX_W-1:0] idx_b;
    } enc_t;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic             db;
        logic [TAG_W-1:0] tag;
    } word_t;

    typedef struct packed {
        logic             stall;
        logic [OFF_W-1:0] off;
        s1_t              s1;
        enc_t             s2;
        enc_t             s3;
        word_t            out;
        word_t            pend;
    } state_t;
endpackage

// File: rtl/tcam_bank.sv
module tcam_bank #(
    parameter int W     = 128,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wval,
    input  logic [W-1:0]     wmsk,
    input  logic [W-1:0]     key,
    output logic [DEPTH-1:0] match
);
    logic [W-1:0]     val_q [DEPTH];
    logic [W-1:0]     val_d [DEPTH];
    logic [W-1:0]     msk_q [DEPTH];
    logic [W-1:0]     msk_d [DEPTH];
    logic [DEPTH-1:0] live_q, live_d;

    always_comb begin
        val_d  = val_q;
        msk_d  = msk_q;
        live_d = live_q;
        if (we) begin
            val_d[widx]  = wval;
            msk_d[widx]  = wmsk;
            live_d[widx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
        val_q <= val_d;
        msk_q <= msk_d;
    end

    // compare against the registered contents only
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = live_q[i] && (((key ^ val_q[i]) & msk_q[i]) == '0);
    end
endmodule

// File: rtl/prio_enc.sv
module prio_enc #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/subkey_sel.sv
module subkey_sel #(
    parameter int KEY_W = 252,
    parameter int SUB_W = 128,
    parameter int OFF_W = 7
) (
    input  logic [KEY_W-1:0] key,
    input  logic [OFF_W-1:0] off,
    output logic [SUB_W-1:0] sub
);
    logic [KEY_W-1:0] shifted;
    assign shifted = key >> off;
    assign sub     = shifted[SUB_W-1:0];
endmodule

// File: rtl/dual_lookup_engine.sv
module dual_lookup_engine
    import dle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [KEY_W-1:0] cmd_key,
    input  logic             cmd_dual,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic             cfg_we,
    input  logic [OFF_W-1:0] cfg_off,
    input  logic             wr_en,
    input  logic             wr_db,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic             res_db,
    output logic [TAG_W-1:0] res_tag
);
    state_t st_q, st_d;

    logic             accept;
    logic [SUB_W-1:0] sub_key;
    logic [DEPTH-1:0] match_a, match_b;
    logic             enc_hit_a, enc_hit_b;
    logic [IDX_W-1:0] enc_idx_a, enc_idx_b;

    assign cmd_ready = !st_q.stall;
    assign accept    = cmd_valid && cmd_ready;

    subkey_sel #(.KEY_W(KEY_W), .SUB_W(SUB_W), .OFF_W(OFF_W)) u_sub (
        .key(cmd_key), .off(st_q.off), .sub(sub_key)
    );

    tcam_bank #(.W(KEY_W), .DEPTH(DEPTH)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .we(wr_en && !wr_db), .widx(wr_idx),
        .wval(wr_value), .wmsk(wr_mask), .key(cmd_key), .match(match_a)
    );

    tcam_bank #(.W(SUB_W), .DEPTH(DEPTH)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_db), .widx(wr_idx),
        .wval(wr_value[SUB_W-1:0]), .wmsk(wr_mask[SUB_W-1:0]),
        .key(sub_key), .match(match_b)
    );

    prio_enc #(.DEPTH(DEPTH)) u_enc_a (
        .vec(st_q.s1.vec_a), .hit(enc_hit_a), .idx(enc_idx_a)
    );
    prio_enc #(.DEPTH(DEPTH)) u_enc_b (
        .vec(st_q.s1.vec_b), .hit(enc_hit_b), .idx(enc_idx_b)
    );

    always_comb begin
        st_d = st_q;

        // one bubble after a dual command frees the slot for word B
        st_d.stall = accept && cmd_dual;

        if (cfg_we && (int'(cfg_off) <= MAX_OFF)) st_d.off = cfg_off;

        // stage 1: compare in the acceptance cycle, before any same-edge write lands
        st_d.s1.vld   = accept;
        st_d.s1.dual  = cmd_dual;
        st_d.s1.tag   = cmd_tag;
        st_d.s1.vec_a = match_a;
        st_d.s1.vec_b = match_b;

        // stage 2: priority encode
        st_d.s2.vld   = st_q.s1.vld;
        st_d.s2.dual  = st_q.s1.dual;
        st_d.s2.tag   = st_q.s1.tag;
        st_d.s2.hit_a = enc_hit_a;
        st_d.s2.idx_a = enc_idx_a;
        st_d.s2.hit_b = enc_hit_b;
        st_d.s2.idx_b = enc_idx_b;

        // stage 3: alignment register
        st_d.s3 = st_q.s2;

        // output: word A first, word B parked for the next cycle
        st_d.pend.vld = 1'b0;
        if (st_q.s3.vld) begin
            st_d.out.vld  = 1'b1;
            st_d.out.hit  = st_q.s3.hit_a;
            st_d.out.idx  = st_q.s3.idx_a;
            st_d.out.db   = 1'b0;
            st_d.out.tag  = st_q.s3.tag;
            st_d.pend.vld = st_q.s3.dual;
            st_d.pend.hit = st_q.s3.hit_b;
            st_d.pend.idx = st_q.s3.idx_b;
            st_d.pend.db  = 1'b1;
            st_d.pend.tag = st_q.s3.tag;
        end else if (st_q.pend.vld) begin
            st_d.out = st_q.pend;
        end else begin
            st_d.out.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.out.vld;
    assign res_hit   = st_q.out.hit;
    assign res_idx   = st_q.out.idx;
    assign res_db    = st_q.out.db;
    assign res_tag   = st_q.out.tag;
endmodule

// File: rtl/dle_checker.sv
module dle_checker
    import dle_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_dual,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic             res_db,
    input logic [TAG_W-1:0] res_tag
);
    logic       acc;
    logic [4:0] acc_h, dual_h;

    assign acc = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_h  <= '0;
            dual_h <= '0;
        end else begin
            acc_h  <= {acc_h[3:0], acc};
            dual_h <= {dual_h[3:0], acc && cmd_dual};
        end
    end

    AST_A_WORD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_h[3] |-> (res_valid && !res_db)); // R2
    AST_NO_STRAY_A_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_db) |-> acc_h[3]); // R2
    AST_B_WORD_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        dual_h[4] |-> (res_valid && res_db)); // R5
    AST_NO_STRAY_B_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_db) |-> dual_h[4]); // R5
    AST_B_SAME_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_db) |-> ($past(res_valid) && res_tag == $past(res_tag))); // R5
    AST_STALL_AFTER_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_dual) |=> !cmd_ready); // R8
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready); // R8
    AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '0)); // R4
endmodule

bind dual_lookup_engine dle_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dual(cmd_dual), .res_valid(res_valid), .res_hit(res_hit),
    .res_idx(res_idx), .res_db(res_db), .res_tag(res_tag)
);

// File: tb/dual_lookup_engine_test.sv
`timescale 1ns/1ps
module dual_lookup_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [251:0] cmd_key = '0;
    logic         cmd_dual = 1'b0;
    logic [3:0]   cmd_tag = '0;
    logic         cfg_we = 1'b0;
    logic [6:0]   cfg_off = '0;
    logic         wr_en = 1'b0;
    logic         wr_db = 1'b0;
    logic [3:0]   wr_idx = '0;
    logic [251:0] wr_value = '0;
    logic [251:0] wr_mask = '0;
    logic         res_valid, res_hit, res_db;
    logic [3:0]   res_idx, res_tag;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [251:0] kp, kq;
    logic [127:0] ks, kt;

    always #5 clk = ~clk;

    dual_lookup_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_key(cmd_key), .cmd_dual(cmd_dual), .cmd_tag(cmd_tag),
        .cfg_we(cfg_we), .cfg_off(cfg_off), .wr_en(wr_en), .wr_db(wr_db),
        .wr_idx(wr_idx), .wr_value(wr_value), .wr_mask(wr_mask),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_db(res_db), .res_tag(res_tag)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic write_entry(input bit db, input int idx, input logic [251:0] v,
                               input logic [251:0] m);
        wr_en = 1'b1; wr_db = db; wr_idx = 4'(idx); wr_value = v; wr_mask = m;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_offset(input int off);
        cfg_we = 1'b1; cfg_off = 7'(off);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called just after a falling edge; any write set up by the caller lands at the same edge
    task automatic lookup(input logic [251:0] k, input bit dual, input logic [3:0] tag,
                          input bit eha, input int eia, input bit ehb, input int eib,
                          input string rq);
        chk({rq, " ready before command (R8)"}, 32'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_key = k; cmd_dual = dual; cmd_tag = tag;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; wr_en = 1'b0;
        chk({rq, " ready after accept R8"}, 32'(cmd_ready), 32'(!dual));
        @(negedge clk);
        chk({rq, " ready recovered R8"}, 32'(cmd_ready), 1);
        @(negedge clk);
        chk({rq, " no early word R2"}, 32'(res_valid), 0);
        @(negedge clk);
        chk({rq, " word A valid R2"}, {res_valid, res_db, res_tag}, {1'b1, 1'b0, tag});
        chk({rq, " word A hit/idx"}, {res_hit, res_idx}, {eha, 4'(eia)});
        @(negedge clk);
        if (dual) begin
            chk({rq, " word B valid R5"}, {res_valid, res_db, res_tag}, {1'b1, 1'b1, tag});
            chk({rq, " word B hit/idx"}, {res_hit, res_idx}, {ehb, 4'(eib)});
            @(negedge clk);
        end
        chk({rq, " no extra word R5"}, 32'(res_valid), 0);
    endtask

    task automatic t_reset;
        chk("R1 ready", 32'(cmd_ready), 1);
        chk("R1 res_valid", 32'(res_valid), 0);
        lookup('0, 1'b1, 4'h1, 0, 0, 0, 0, "R1 empty tables miss");
    endtask

    task automatic t_fill;
        write_entry(0, 3, kp, '1);                  // exact
        write_entry(0, 5, kp, 252'hFF);             // low byte only
        write_entry(1, 2, {124'd0, ks}, '1);        // exact sub-key
        write_entry(1, 7, '0, '0);                  // catch-all
    endtask

    task automatic t_single;
        lookup(kp, 0, 4'h2, 1, 3, 0, 0, "R4 lowest slot wins");
        lookup(kp ^ (252'd1 << 200), 0, 4'h3, 1, 5, 0, 0, "R3 masked bit ignored");
        lookup(kp ^ 252'd1, 0, 4'h4, 0, 0, 0, 0, "R3 cared bit mismatch R4 miss");
    endtask

    task automatic t_window;
        lookup({124'd0, ks}, 1, 4'h5, 0, 0, 1, 2, "R6 offset 0 exact");
        lookup({124'd0, ks} << 100, 1, 4'h6, 0, 0, 1, 7, "R6 offset 0 other window");
        set_offset(100);
        lookup({124'd0, ks} << 100, 1, 4'h7, 0, 0, 1, 2, "R6 offset 100");
        lookup({124'd0, ks}, 1, 4'h8, 0, 0, 1, 7, "R6 offset 100 low bits");
        set_offset(125);
        lookup({124'd0, ks} << 100, 1, 4'h9, 0, 0, 1, 2, "R7 bad offset ignored");
        set_offset(127);
        lookup({124'd0, ks} << 100, 1, 4'hA, 0, 0, 1, 2, "R7 top bad offset ignored");
        set_offset(124);
        lookup({124'd0, ks} << 124, 1, 4'hB, 0, 0, 1, 2, "R6 offset 124 edge");
        set_offset(0);
    endtask

    task automatic t_write_timing;
        wr_en = 1'b1; wr_db = 1'b0; wr_idx = 4'd1; wr_value = kq; wr_mask = '1;
        lookup(kq, 0, 4'hC, 0, 0, 0, 0, "R9 same-edge write unseen");
        lookup(kq, 0, 4'hD, 1, 1, 0, 0, "R9 later command sees write");
        lookup(kp, 0, 4'hE, 1, 1 == 0 ? 0 : 3, 0, 0, "R4 slot 3 still wins for kp");
    endtask

    task automatic t_isolation;
        write_entry(1, 0, {{124{1'b1}}, kt}, '1);
        lookup({124'd0, kt}, 1, 4'h1, 0, 0, 1, 0, "R10 table B low bits written");
        lookup(kp, 1, 4'h2, 1, 3, 1, 7, "R10 table A unchanged");
        write_entry(0, 0, kq, '1);
        lookup({124'd0, ks}, 1, 4'h3, 0, 0, 1, 2, "R10 table B unchanged by A write");
    endtask

    task automatic t_stream;
        logic [251:0] keys [3];
        int exp_idx [3];
        keys[0] = kp; keys[1] = kp ^ (252'd1 << 200); keys[2] = {124'd0, ks};
        exp_idx[0] = 3; exp_idx[1] = 5; exp_idx[2] = 0;
        for (int i = 0; i < 3; i++) begin
            cmd_valid = 1'b1; cmd_key = keys[i]; cmd_dual = 1'b0; cmd_tag = 4'(i + 4);
            @(posedge clk);
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 streamed word", {res_valid, res_db, res_tag, res_hit, res_idx},
                {1'b1, 1'b0, 4'(i + 4), exp_idx[i] != 0, 4'(exp_idx[i])});
        end
        @(negedge clk);
        chk("R11 stream ends", 32'(res_valid), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        kp = {63{4'h9}} ^ 252'hF00D;
        kq = ~kp;
        ks = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_0F1E_2D3C;
        kt = 128'h5555_AAAA_1234_5678_9ABC_DEF0_2468_AC11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_single();
        t_window();
        t_write_timing();
        t_isolation();
        t_stream();
        finish_run();
    end
endmodule